// File: doc/BRIEF.md
# Vector Condition-Code Test Unit

This block keeps a four-lane condition register and uses it to gate the write of each lane of an instruction's result. Each lane of the condition register holds two flags: negative and zero. An instruction that turns testing on picks one of eight comparison conditions. It also gives each result lane a 2-bit selector, which chooses the condition-register lane that result lane is tested against. A lane is written only when its write-mask bit is set and its selected flags satisfy the condition. When testing is off, the mask passes through unchanged.

The unit also drives a branch indication: it is high when any lane passes the test. A sequencer uses it for conditional jumps, and for loops built from a counter held in a temporary register. An instruction may also ask for its four-lane result to be captured. The sign and zero of each result lane are then loaded into the condition register at the clock edge. Any test made by that same instruction sees the flags as they were before the capture.

Instructions arrive one per cycle and every decision is combinational within that cycle, so the block has no valid/ready handshake. The only data that moves, the result, is absorbed at the next edge whenever the update enable is high. All of the block's pins are control or status pins.

Top module: `ccu_cond_unit`

## Requirements
- R1: `cond_sel` encodes the condition as follows: 0 never, 1 negative, 2 zero, 3 negative or zero, 4 neither negative nor zero, 5 not zero, 6 not negative, 7 always.
- R2: When `test_en` is low, `wr_en` equals `wr_mask` and `br_taken` is high, whatever `cond_sel` and `comp_sel` hold.
- R3: The selector for result lane k is `comp_sel[2k+1:2k]`, where 0 chooses condition lane X, 1 chooses Y, 2 chooses Z and 3 chooses W. Several lanes may choose the same condition lane.
- R4: Result lane k is `res_data[k*DATA_W +: DATA_W]`, with lane 0 being X. In the default floating-point format, a lane is zero when all bits below the sign bit are clear. It is negative when the sign bit is set and the lane is not zero, so minus zero counts as zero and not negative.
- R5: When `test_en` is high, `wr_en[k]` is high only if `wr_mask[k]` is high and lane k passes its test.
- R6: When `test_en` is high, `br_taken` is high exactly when at least one lane passes its test, whatever the value of `wr_mask`.
- R7: When `upd_en` is high at a rising edge, the flags of all four result lanes are loaded into the condition register. When it is low, the register holds its value.
- R8: An instruction that both tests and updates is tested against the flags from before the update. The new flags affect the next instruction.
- R9: A synchronous reset sets every condition lane to zero and not negative.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| test_en | input | 1 | Enables conditional gating of the write mask |
| cond_sel | input | 3 | Condition code, encoded as in R1 |
| comp_sel | input | 8 | Four 2-bit selectors that choose condition lanes, laid out as in R3 |
| wr_mask | input | 4 | Write mask for the destination, one bit per lane |
| upd_en | input | 1 | Loads the flags of `res_data` at the next edge |
| res_data | input | 4*DATA_W | Four-lane instruction result |
| wr_en | output | 4 | Final write enable for each lane |
| br_taken | output | 1 | Test passed on at least one lane, or testing is off |

## Verification
The assertions assume that `cond_sel`, `comp_sel`, `wr_mask` and the enables keep the same value through a cycle. They also assume that reset is held for at least one edge before any flag check counts. The bench satisfies both by changing inputs only on the falling edge and holding reset over two rising edges. Results are drawn from plus one, minus one, plus zero, minus zero and random words, so that every flag combination and the minus-zero corner are reached. Updates are mixed with tests in the same cycle.

// File: rtl/ccu_pkg.sv
package ccu_pkg;

  localparam int unsigned LANES = 4;
  localparam int unsigned SEL_W = $clog2(LANES);

  typedef enum logic [2:0] {
    CC_NEVER  = 3'd0,
    CC_LT     = 3'd1,
    CC_EQ     = 3'd2,
    CC_LE     = 3'd3,
    CC_GT     = 3'd4,
    CC_NE     = 3'd5,
    CC_GE     = 3'd6,
    CC_ALWAYS = 3'd7
  } cc_cond_e;

  typedef struct packed {
    logic neg;
    logic zero;
  } cc_flag_t;

  localparam cc_flag_t CC_FLAG_INIT = '{neg: 1'b0, zero: 1'b1};

  // Evaluate one condition against one lane's stored flags.
  function automatic logic cc_eval(cc_cond_e c, cc_flag_t f);
    logic r;
    case (c)
      CC_NEVER: r = 1'b0;
      CC_LT:    r = f.neg;
      CC_EQ:    r = f.zero;
      CC_LE:    r = f.neg | f.zero;
      CC_GT:    r = ~f.neg & ~f.zero;
      CC_NE:    r = ~f.zero;
      CC_GE:    r = ~f.neg;
      default:  r = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ccu_flag_detect.sv
module ccu_flag_detect
  import ccu_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter bit          FLOAT_FMT = 1'b1
) (
  input  logic [LANES*DATA_W-1:0] res,
  output cc_flag_t [LANES-1:0]    flags
);

  localparam int unsigned MSB = DATA_W - 1;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [DATA_W-1:0] word;
    logic              is_zero;
    logic              is_neg;
    assign word = res[k*DATA_W +: DATA_W];
    if (FLOAT_FMT) begin : g_float
      // Sign-magnitude: both zero encodings count as zero.
      assign is_zero = ~|word[MSB-1:0];
      assign is_neg  = word[MSB] & ~is_zero;
    end else begin : g_int
      assign is_zero = ~|word;
      assign is_neg  = word[MSB];
    end
    assign flags[k] = '{neg: is_neg, zero: is_zero};
  end

endmodule

// File: rtl/ccu_flag_reg.sv
module ccu_flag_reg
  import ccu_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 upd_en,
  input  cc_flag_t [LANES-1:0] nxt,
  output cc_flag_t [LANES-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= {LANES{CC_FLAG_INIT}};
    end else if (upd_en) begin
      q <= nxt;
    end
  end

endmodule

// File: rtl/ccu_lane_test.sv
module ccu_lane_test
  import ccu_pkg::*;
(
  input  logic                   test_en,
  input  logic [2:0]             cond_sel,
  input  logic [LANES*SEL_W-1:0] comp_sel,
  input  logic [LANES-1:0]       wr_mask,
  input  cc_flag_t [LANES-1:0]   flags_q,
  output logic [LANES-1:0]       wr_en,
  output logic                   br_taken
);

  cc_cond_e          cond;
  logic [LANES-1:0]  pass;

  assign cond = cc_cond_e'(cond_sel);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [SEL_W-1:0] pick;
    cc_flag_t         seen;
    assign pick    = comp_sel[k*SEL_W +: SEL_W];
    assign seen    = flags_q[pick];
    assign pass[k] = cc_eval(cond, seen);
  end

  always_comb begin
    if (test_en) begin
      wr_en    = wr_mask & pass;
      br_taken = |pass;
    end else begin
      wr_en    = wr_mask;
      br_taken = 1'b1;
    end
  end

endmodule

// File: rtl/ccu_cond_unit.sv
module ccu_cond_unit
  import ccu_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter bit          FLOAT_FMT = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   test_en,
  input  logic [2:0]             cond_sel,
  input  logic [LANES*SEL_W-1:0] comp_sel,
  input  logic [LANES-1:0]       wr_mask,
  input  logic                   upd_en,
  input  logic [LANES*DATA_W-1:0] res_data,
  output logic [LANES-1:0]       wr_en,
  output logic                   br_taken
);

  cc_flag_t [LANES-1:0] flags_nxt;
  cc_flag_t [LANES-1:0] flags_q;

  ccu_flag_detect #(
    .DATA_W   (DATA_W),
    .FLOAT_FMT(FLOAT_FMT)
  ) u_detect (
    .res  (res_data),
    .flags(flags_nxt)
  );

  ccu_flag_reg u_flags (
    .clk   (clk),
    .rst   (rst),
    .upd_en(upd_en),
    .nxt   (flags_nxt),
    .q     (flags_q)
  );

  // Tests read the registered flags only, so a same-cycle update is unseen.
  ccu_lane_test u_test (
    .test_en (test_en),
    .cond_sel(cond_sel),
    .comp_sel(comp_sel),
    .wr_mask (wr_mask),
    .flags_q (flags_q),
    .wr_en   (wr_en),
    .br_taken(br_taken)
  );

endmodule

// File: rtl/ccu_cond_unit_chk.sv
module ccu_cond_unit_chk #(
  parameter int unsigned LN = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            test_en,
  input logic [2:0]      cond_sel,
  input logic [LN-1:0]   wr_mask,
  input logic            upd_en,
  input logic [LN-1:0]   wr_en,
  input logic            br_taken,
  input logic [2*LN-1:0] flags_q
);

  localparam logic [2*LN-1:0] ZBITS = {LN{2'b01}};

  // R2
  passthru_chk: assert property (@(posedge clk) disable iff (rst)
    !test_en |-> (wr_en == wr_mask && br_taken));

  // R5
  mask_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en & ~wr_mask) == '0);

  // R1
  never_cond_chk: assert property (@(posedge clk) disable iff (rst)
    (test_en && cond_sel == 3'd0) |-> (wr_en == '0 && !br_taken));

  // R1
  always_cond_chk: assert property (@(posedge clk) disable iff (rst)
    (test_en && cond_sel == 3'd7) |-> (wr_en == wr_mask && br_taken));

  // R6
  branch_any_chk: assert property (@(posedge clk) disable iff (rst)
    (test_en && wr_en != '0) |-> br_taken);

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> $stable(flags_q));

  // R9
  flag_reset_chk: assert property (@(posedge clk)
    rst |=> flags_q == ZBITS);

  // R4
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (flags_q & (flags_q >> 1) & ZBITS) == '0);

endmodule

bind ccu_cond_unit ccu_cond_unit_chk #(.LN(4)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .test_en (test_en),
  .cond_sel(cond_sel),
  .wr_mask (wr_mask),
  .upd_en  (upd_en),
  .wr_en   (wr_en),
  .br_taken(br_taken),
  .flags_q (flags_q)
);

// File: tb/tb_ccu_cond_unit.sv
module tb_ccu_cond_unit;

  localparam int DW = 32;
  localparam logic [DW-1:0] P1 = 32'h3f80_0000;
  localparam logic [DW-1:0] M1 = 32'hbf80_0000;
  localparam logic [DW-1:0] PZ = 32'h0000_0000;
  localparam logic [DW-1:0] MZ = 32'h8000_0000;

  logic          clk = 1'b0;
  logic          rst;
  logic          test_en;
  logic [2:0]    cond_sel;
  logic [7:0]    comp_sel;
  logic [3:0]    wr_mask;
  logic          upd_en;
  logic [4*DW-1:0] res_data;
  logic [3:0]    wr_en;
  logic          br_taken;

  always #2 clk = ~clk;

  ccu_cond_unit #(.DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .test_en(test_en), .cond_sel(cond_sel),
    .comp_sel(comp_sel), .wr_mask(wr_mask), .upd_en(upd_en),
    .res_data(res_data), .wr_en(wr_en), .br_taken(br_taken)
  );

  int checks = 0;
  int errors = 0;
  bit m_neg  [4];
  bit m_zero [4];

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit cond_ok(int c, bit n, bit z);
    case (c)
      0: return 1'b0;
      1: return n;
      2: return z;
      3: return n | z;
      4: return !n && !z;
      5: return !z;
      6: return !n;
      default: return 1'b1;
    endcase
  endfunction

  // Drive one instruction, check it against the model, then apply its update.
  task automatic step(bit te, int cs, logic [7:0] cm, logic [3:0] wm, bit ue,
                      logic [DW-1:0] w, logic [DW-1:0] z, logic [DW-1:0] y,
                      logic [DW-1:0] x, string tag);
    int exp_wr;
    bit any;
    @(negedge clk);
    test_en = te; cond_sel = 3'(cs); comp_sel = cm; wr_mask = wm;
    upd_en = ue; res_data = {w, z, y, x};
    #1;
    exp_wr = 0;
    any = 1'b0;
    for (int k = 0; k < 4; k++) begin
      int s;
      bit p;
      s = int'(cm[2*k +: 2]);
      p = cond_ok(cs, m_neg[s], m_zero[s]);
      any = any | p;
      if (!te || p) exp_wr = exp_wr | (int'(wm[k]) << k);
    end
    chk({tag, " wr_en"}, int'(wr_en), exp_wr);
    chk({tag, " br_taken"}, int'(br_taken), te ? int'(any) : 1);
    if (ue) begin
      for (int k = 0; k < 4; k++) begin
        logic [DW-1:0] v;
        v = res_data[k*DW +: DW];
        m_zero[k] = (v[DW-2:0] == '0);
        m_neg[k]  = v[DW-1] && !m_zero[k];
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; test_en = 1'b0; cond_sel = '0; comp_sel = '0;
    wr_mask = '0; upd_en = 1'b0; res_data = '0;
    repeat (2) @(posedge clk);
    for (int k = 0; k < 4; k++) begin m_neg[k] = 1'b0; m_zero[k] = 1'b1; end
    @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic logic [DW-1:0] pick_val(int r);
    case (r % 5)
      0: return P1;
      1: return M1;
      2: return PZ;
      3: return MZ;
      default: return DW'($urandom);
    endcase
  endfunction

  bit done = 1'b0;

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R9: after reset every lane reads zero and not negative
    step(1, 2, 8'hE4, 4'hF, 0, P1, P1, P1, P1, "R9 eq");
    chk("R9 eq explicit", int'(wr_en), 4'hF);
    step(1, 1, 8'hE4, 4'hF, 0, P1, P1, P1, P1, "R9 lt");
    chk("R9 lt explicit", int'(wr_en), 0);
    // R2: test disabled passes mask through
    step(0, 0, 8'h1B, 4'h5, 0, P1, P1, P1, P1, "R2");
    chk("R2 explicit", int'(wr_en), 4'h5);
    // R7: load X=-1, Y=+0, Z=+1, W=-0
    step(0, 0, 8'hE4, 4'h0, 1, MZ, P1, PZ, M1, "R7 load");
    // R1: every condition with identity selectors
    for (int c = 0; c < 8; c++) step(1, c, 8'hE4, 4'hF, 0, P1, P1, P1, P1, "R1");
    step(1, 1, 8'hE4, 4'hF, 0, P1, P1, P1, P1, "R4 lt");
    chk("R4 minus zero not negative", int'(wr_en), 4'b0001);
    step(1, 2, 8'hE4, 4'hF, 0, P1, P1, P1, P1, "R4 eq");
    chk("R4 minus zero is zero", int'(wr_en), 4'b1010);
    // R3: broadcast Z (positive) and X (negative)
    step(1, 4, 8'hAA, 4'hF, 0, P1, P1, P1, P1, "R3 bcast z");
    chk("R3 bcast z explicit", int'(wr_en), 4'hF);
    step(1, 4, 8'h00, 4'hF, 0, P1, P1, P1, P1, "R3 bcast x");
    chk("R3 bcast x explicit", int'(wr_en), 0);
    step(1, 1, 8'h1B, 4'hF, 0, P1, P1, P1, P1, "R3 reversed");
    chk("R3 reversed explicit", int'(wr_en), 4'b1000);
    // R5: mask gates passing lanes
    step(1, 4, 8'hAA, 4'h6, 0, P1, P1, P1, P1, "R5");
    chk("R5 explicit", int'(wr_en), 4'h6);
    // R6: branch ignores mask
    step(1, 5, 8'hE4, 4'h0, 0, P1, P1, P1, P1, "R6 ne");
    chk("R6 ne explicit", int'(br_taken), 1);
    step(1, 0, 8'hE4, 4'hF, 0, P1, P1, P1, P1, "R6 never");
    chk("R6 never explicit", int'(br_taken), 0);
    // R8: test with old flags while loading all-positive
    step(1, 2, 8'hE4, 4'hF, 1, P1, P1, P1, P1, "R8 same");
    chk("R8 old flags", int'(wr_en), 4'b1010);
    step(1, 2, 8'hE4, 4'hF, 0, PZ, PZ, PZ, PZ, "R8 next");
    chk("R8 new flags", int'(wr_en), 0);
    // R7: no update keeps flags
    step(1, 4, 8'hE4, 4'hF, 0, M1, M1, M1, M1, "R7 hold");
    chk("R7 hold explicit", int'(wr_en), 4'hF);
    // R9: reset mid-run
    do_reset();
    step(1, 2, 8'hE4, 4'hF, 0, P1, P1, P1, P1, "R9 rerun");
    chk("R9 rerun explicit", int'(wr_en), 4'hF);
    // R5 R8: random mixes
    for (int i = 0; i < 400; i++) begin
      step(bit'($urandom_range(0, 3) != 0), int'($urandom_range(0, 7)),
           8'($urandom), 4'($urandom), bit'($urandom),
           pick_val(int'($urandom_range(0, 99))), pick_val(int'($urandom_range(0, 99))),
           pick_val(int'($urandom_range(0, 99))), pick_val(int'($urandom_range(0, 99))),
           "R5 random");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule